// File: doc/BRIEF.md
# Domain and Access-Permission Fault Checker

This block makes the allow-or-fault decision for a memory access after a translation lookup has hit. It takes the matched entry's domain number, its 3-bit access-permission code, its execute-never bit and its section-or-page flag. It also takes the per-domain access control word, the permission-decode control bits, the privilege of the request, and whether the request is an instruction fetch or a write. One clock cycle later it reports the verdict on registered outputs.

The decision has two levels. First, a 2-bit mode for the entry's domain is taken from the control word. That mode blocks the access, sends it on to the permission check, or lets it through unchecked as a manager. Second, for checked domains the permission code is decoded against privilege and direction. An old-style encoding is steered by two extra select bits. A fault is classed as a prefetch abort or a data abort, and it carries a cause, a 4-bit code and, for data aborts only, the domain number and the write flag. Reserved encodings raise a separate flag and are also treated as faults.

Top module: `acc_guard`

## Requirements
- R1: A request presented with `req_vld` high produces its result, with `rsp_vld` high, on the outputs one clock edge later. A cycle with `req_vld` low leaves every output at zero after the next edge.
- R2: The domain mode is `dac_word[2*dom_idx+1 : 2*dom_idx]`. Mode 0 gives a fault with `cause`=0 (domain) and `allow`=0, whatever the other fields of the word hold.
- R3: Mode 3 gives `allow`=1 and `mgr_bypass`=1 with no fault. The permission code and execute-never are not examined, so a fetch with execute-never set and a permission code of 4 are both allowed with `unpred`=0.
- R4: Mode 2 is reserved. It gives a domain fault (`cause`=0) and `unpred`=1.
- R5: With `afe_en` high, bit 0 of the permission code is forced to 1 before decoding (0 acts as 1, 4 acts as 5).
- R6: Code 0 with `xp_en` high always faults. With `xp_en` low it decodes by `rs_sel`: 2 faults only on writes, 1 faults on writes or user accesses, and 0 or 3 always fault.
- R7: Code 1 faults on user accesses. Code 2 faults on user writes. Code 3 never faults. Code 5 faults on user accesses or on any write. Codes 6 and 7 fault on writes. A permission fault has `cause`=1.
- R8: Code 4 in a checked domain is reserved. It gives a permission fault with `unpred`=1.
- R9: `abort_kind` is 1 (prefetch abort) for any fault on a fetch, and 0 (data abort) otherwise. On a fetch in a checked domain, execute-never set gives a permission fault even if the code allows the access. Execute-never has no effect on non-fetch accesses.
- R10: `fault_code` is 4'b0101 for a domain fault on a section and 4'b0111 on a page. It is 4'b1101 for a permission fault on a section and 4'b1111 on a page (`page_lvl` high means page). It is zero with no fault.
- R11: A data abort drives `rep_dom` with the domain number and `rep_wr` with the write flag. A prefetch abort, or no fault, drives both to zero.
- R12: A request counts as privileged only when `core_priv` is high and `force_user` is low.
- R13: Synchronous active-high `rst` clears every output at the next edge, even when a request is presented in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Request present this cycle |
| dom_idx | input | DOM_W | Domain number of the hit entry |
| ap_bits | input | 3 | Access-permission code of the entry |
| xn | input | 1 | Execute-never bit of the entry |
| page_lvl | input | 1 | 1 = page mapping, 0 = section mapping |
| dac_word | input | 2*NUM_DOM | Per-domain 2-bit mode fields |
| afe_en | input | 1 | Force permission bit 0 to 1 |
| xp_en | input | 1 | Extended permission model; disables select decode for code 0 |
| rs_sel | input | 2 | Old-style select for code 0 |
| core_priv | input | 1 | Core is running privileged |
| force_user | input | 1 | Request is forced to user-mode checking |
| is_fetch | input | 1 | Instruction fetch |
| is_write | input | 1 | Write access |
| rsp_vld | output | 1 | Result valid |
| allow | output | 1 | Access granted |
| fault | output | 1 | Access faulted |
| abort_kind | output | 1 | 1 = prefetch abort, 0 = data abort |
| cause | output | 1 | 1 = permission, 0 = domain |
| fault_code | output | 4 | Level-qualified fault code |
| mgr_bypass | output | 1 | Allowed through a manager domain |
| unpred | output | 1 | Reserved encoding was hit |
| rep_dom | output | DOM_W | Domain number reported with a data abort |
| rep_wr | output | 1 | Write flag reported with a data abort |

## Verification
The bench builds the block with its default of 16 domains. The 4-bit domain number therefore covers every field of the 32-bit control word, including the top field at bits 31:30. In every vector, all fields other than the selected one are filled with the bitwise inverse of the selected mode. A wrong field pick then turns an allowed access into a fault, or a fault into a grant. Back-to-back requests run through every permission code under both privilege levels and both directions, all four select values, forced user mode, and fetches with execute-never set. They are followed by idle and reset cycles.

// File: rtl/acc_guard_pkg.sv
package acc_guard_pkg;

  typedef enum logic [1:0] {
    DM_BLOCK   = 2'd0,
    DM_CLIENT  = 2'd1,
    DM_RSVD    = 2'd2,
    DM_MANAGER = 2'd3
  } dom_mode_e;

  typedef enum logic {
    ABT_DATA  = 1'b0,
    ABT_FETCH = 1'b1
  } abort_kind_e;

  typedef enum logic {
    CAUSE_DOMAIN = 1'b0,
    CAUSE_PERM   = 1'b1
  } cause_e;

  localparam int AP_W   = 3;
  localparam int RS_W   = 2;
  localparam int CODE_W = 4;

  // Code layout: {permission, 1, page, 1}
  function automatic logic [CODE_W-1:0] make_code(cause_e c, logic pg);
    return {c == CAUSE_PERM, 1'b1, pg, 1'b1};
  endfunction

endpackage

// File: rtl/acc_guard_dom_sel.sv
module acc_guard_dom_sel
  import acc_guard_pkg::*;
#(
  parameter int NUM_DOM = 16,
  parameter int DOM_W   = 4
) (
  input  logic [2*NUM_DOM-1:0] ctl_word,
  input  logic [DOM_W-1:0]     idx,
  output dom_mode_e            mode
);

  logic [1:0] field [NUM_DOM];

  for (genvar g = 0; g < NUM_DOM; g++) begin : g_fld
    assign field[g] = ctl_word[2*g +: 2];
  end

  // Out-of-range index (non power-of-two count) reads as blocked
  always_comb begin
    mode = DM_BLOCK;
    for (int i = 0; i < NUM_DOM; i++) begin
      if (idx == DOM_W'(i)) mode = dom_mode_e'(field[i]);
    end
  end

endmodule

// File: rtl/acc_guard_ap_dec.sv
module acc_guard_ap_dec
  import acc_guard_pkg::*;
(
  input  logic [AP_W-1:0] ap_raw,
  input  logic            afe_en,
  input  logic            xp_en,
  input  logic [RS_W-1:0] rs_sel,
  input  logic            priv,
  input  logic            wr,
  output logic            deny,
  output logic            rsvd
);

  logic [AP_W-1:0] ap_eff;

  always_comb begin
    ap_eff = ap_raw | {{(AP_W-1){1'b0}}, afe_en};
    deny   = 1'b1;
    rsvd   = 1'b0;
    case (ap_eff)
      3'd0: begin
        if (xp_en) begin
          deny = 1'b1;
        end else begin
          case (rs_sel)
            2'd2:    deny = wr;
            2'd1:    deny = wr || !priv;
            default: deny = 1'b1;
          endcase
        end
      end
      3'd1: deny = !priv;
      3'd2: deny = !priv && wr;
      3'd3: deny = 1'b0;
      3'd4: begin
        deny = 1'b1;
        rsvd = 1'b1;
      end
      3'd5: deny = !priv || wr;
      default: deny = wr;
    endcase
  end

endmodule

// File: rtl/acc_guard_resolve.sv
module acc_guard_resolve
  import acc_guard_pkg::*;
#(
  parameter int DOM_W = 4
) (
  input  dom_mode_e          mode,
  input  logic               deny,
  input  logic               ap_rsvd,
  input  logic               xn,
  input  logic               fetch,
  input  logic               wr,
  input  logic               pg,
  input  logic [DOM_W-1:0]   dom,
  output logic               flt,
  output abort_kind_e        kind,
  output cause_e             cs,
  output logic [CODE_W-1:0]  code,
  output logic               byp,
  output logic               unp,
  output logic [DOM_W-1:0]   r_dom,
  output logic               r_wr
);

  logic dom_flt, client, perm_flt, data_abt;

  always_comb begin
    client   = (mode == DM_CLIENT);
    dom_flt  = (mode == DM_BLOCK) || (mode == DM_RSVD);
    perm_flt = client && (deny || (fetch && xn));
    flt      = dom_flt || perm_flt;
    cs       = (flt && perm_flt) ? CAUSE_PERM : CAUSE_DOMAIN;
    kind     = (flt && fetch) ? ABT_FETCH : ABT_DATA;
    code     = flt ? make_code(cs, pg) : '0;
    byp      = (mode == DM_MANAGER);
    unp      = (mode == DM_RSVD) || (client && ap_rsvd);
    data_abt = flt && !fetch;
    r_dom    = data_abt ? dom : '0;
    r_wr     = data_abt && wr;
  end

endmodule

// File: rtl/acc_guard.sv
module acc_guard
  import acc_guard_pkg::*;
#(
  parameter int NUM_DOM = 16,
  parameter int DOM_W   = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_vld,
  input  logic [DOM_W-1:0]     dom_idx,
  input  logic [2:0]           ap_bits,
  input  logic                 xn,
  input  logic                 page_lvl,
  input  logic [2*NUM_DOM-1:0] dac_word,
  input  logic                 afe_en,
  input  logic                 xp_en,
  input  logic [1:0]           rs_sel,
  input  logic                 core_priv,
  input  logic                 force_user,
  input  logic                 is_fetch,
  input  logic                 is_write,
  output logic                 rsp_vld,
  output logic                 allow,
  output logic                 fault,
  output logic                 abort_kind,
  output logic                 cause,
  output logic [3:0]           fault_code,
  output logic                 mgr_bypass,
  output logic                 unpred,
  output logic [DOM_W-1:0]     rep_dom,
  output logic                 rep_wr
);

  dom_mode_e         mode_c;
  logic              priv_c, deny_c, aprsvd_c;
  logic              flt_c, byp_c, unp_c, rwr_c;
  abort_kind_e       kind_c;
  cause_e            cs_c;
  logic [CODE_W-1:0] code_c;
  logic [DOM_W-1:0]  rdom_c;

  assign priv_c = core_priv && !force_user;

  acc_guard_dom_sel #(.NUM_DOM(NUM_DOM), .DOM_W(DOM_W)) u_sel (
    .ctl_word (dac_word),
    .idx      (dom_idx),
    .mode     (mode_c)
  );

  acc_guard_ap_dec u_dec (
    .ap_raw (ap_bits),
    .afe_en (afe_en),
    .xp_en  (xp_en),
    .rs_sel (rs_sel),
    .priv   (priv_c),
    .wr     (is_write),
    .deny   (deny_c),
    .rsvd   (aprsvd_c)
  );

  acc_guard_resolve #(.DOM_W(DOM_W)) u_res (
    .mode    (mode_c),
    .deny    (deny_c),
    .ap_rsvd (aprsvd_c),
    .xn      (xn),
    .fetch   (is_fetch),
    .wr      (is_write),
    .pg      (page_lvl),
    .dom     (dom_idx),
    .flt     (flt_c),
    .kind    (kind_c),
    .cs      (cs_c),
    .code    (code_c),
    .byp     (byp_c),
    .unp     (unp_c),
    .r_dom   (rdom_c),
    .r_wr    (rwr_c)
  );

  always_ff @(posedge clk) begin
    if (rst || !req_vld) begin
      rsp_vld    <= 1'b0;
      allow      <= 1'b0;
      fault      <= 1'b0;
      abort_kind <= 1'b0;
      cause      <= 1'b0;
      fault_code <= '0;
      mgr_bypass <= 1'b0;
      unpred     <= 1'b0;
      rep_dom    <= '0;
      rep_wr     <= 1'b0;
    end else begin
      rsp_vld    <= 1'b1;
      allow      <= !flt_c;
      fault      <= flt_c;
      abort_kind <= (kind_c == ABT_FETCH);
      cause      <= (cs_c == CAUSE_PERM);
      fault_code <= code_c;
      mgr_bypass <= byp_c;
      unpred     <= unp_c;
      rep_dom    <= rdom_c;
      rep_wr     <= rwr_c;
    end
  end

endmodule

// File: rtl/acc_guard_chk.sv
module acc_guard_chk #(
  parameter int NUM_DOM = 16,
  parameter int DOM_W   = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 req_vld,
  input logic [DOM_W-1:0]     dom_idx,
  input logic [2:0]           ap_bits,
  input logic                 afe_en,
  input logic [2*NUM_DOM-1:0] dac_word,
  input logic                 rsp_vld,
  input logic                 allow,
  input logic                 fault,
  input logic                 abort_kind,
  input logic                 cause,
  input logic [3:0]           fault_code,
  input logic                 mgr_bypass,
  input logic                 unpred,
  input logic [DOM_W-1:0]     rep_dom,
  input logic                 rep_wr
);

  logic [1:0] sel_mode;
  assign sel_mode = dac_word[2*dom_idx +: 2];

  a_r1_resp_follows_req: assert property (@(posedge clk) disable iff (rst)
    req_vld |=> rsp_vld);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !req_vld |=> !rsp_vld && !allow && !fault);

  a_r2_blocked_domain: assert property (@(posedge clk) disable iff (rst)
    req_vld && sel_mode == 2'd0 |=> fault && !cause);

  a_r3_manager_grants: assert property (@(posedge clk) disable iff (rst)
    mgr_bypass |-> allow && !fault && !unpred);

  a_r4_reserved_mode: assert property (@(posedge clk) disable iff (rst)
    req_vld && sel_mode == 2'd2 |=> fault && unpred && !cause);

  a_r8_reserved_ap: assert property (@(posedge clk) disable iff (rst)
    req_vld && sel_mode == 2'd1 && ap_bits == 3'd4 && !afe_en |=> fault && unpred && cause);

  a_r9_verdict_exclusive: assert property (@(posedge clk) disable iff (rst)
    rsp_vld |-> (allow != fault));

  a_r10_code_nonzero_on_fault: assert property (@(posedge clk) disable iff (rst)
    fault |-> fault_code[0] && fault_code[2]);

  a_r10_code_zero_on_allow: assert property (@(posedge clk) disable iff (rst)
    !fault |-> fault_code == 4'd0);

  a_r11_prefetch_no_report: assert property (@(posedge clk) disable iff (rst)
    abort_kind |-> rep_dom == '0 && !rep_wr);

endmodule

bind acc_guard acc_guard_chk #(.NUM_DOM(NUM_DOM), .DOM_W(DOM_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .req_vld    (req_vld),
  .dom_idx    (dom_idx),
  .ap_bits    (ap_bits),
  .afe_en     (afe_en),
  .dac_word   (dac_word),
  .rsp_vld    (rsp_vld),
  .allow      (allow),
  .fault      (fault),
  .abort_kind (abort_kind),
  .cause      (cause),
  .fault_code (fault_code),
  .mgr_bypass (mgr_bypass),
  .unpred     (unpred),
  .rep_dom    (rep_dom),
  .rep_wr     (rep_wr)
);

// File: tb/acc_guard_tb_top.sv
`timescale 1ns/1ps
module acc_guard_tb_top;

  localparam int NUM_DOM = 16;
  localparam int DOM_W   = 4;
  localparam int NV      = 31;
  localparam int OW      = 17 + DOM_W;

  typedef struct packed {
    logic [3:0] dom;
    logic [1:0] mode;
    logic [2:0] ap;
    logic       xn, pg, afe, xp;
    logic [1:0] rs;
    logic       priv, fuser, fetch, wr;
    logic       flt, kind, cs, byp, unp;
  } vec_t;

  // dom mode ap xn pg afe xp rs priv fuser fetch wr | flt kind cause byp unp
  localparam vec_t VECS [NV] = '{
    '{4'd3, 2'd0,3'd3,1'b0,1'b0,1'b0,1'b1,2'd0,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,1'b0},
    '{4'd15,2'd3,3'd0,1'b1,1'b1,1'b0,1'b1,2'd0,1'b0,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b1,1'b0},
    '{4'd7, 2'd2,3'd3,1'b0,1'b1,1'b0,1'b1,2'd0,1'b1,1'b0,1'b0,1'b1, 1'b1,1'b0,1'b0,1'b0,1'b1},
    '{4'd1, 2'd1,3'd3,1'b0,1'b0,1'b0,1'b1,2'd0,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b0,1'b0,1'b0},
    '{4'd2, 2'd1,3'd1,1'b0,1'b1,1'b0,1'b1,2'd0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b1,1'b0,1'b0},
    '{4'd2, 2'd1,3'd1,1'b0,1'b0,1'b0,1'b1,2'd0,1'b1,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b0,1'b0,1'b0},
    '{4'd4, 2'd1,3'd2,1'b0,1'b0,1'b0,1'b1,2'd0,1'b0,1'b0,1'b0,1'b1, 1'b1,1'b0,1'b1,1'b0,1'b0},
    '{4'd4, 2'd1,3'd2,1'b0,1'b0,1'b0,1'b1,2'd0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0},
    '{4'd5, 2'd1,3'd5,1'b0,1'b1,1'b0,1'b1,2'd0,1'b1,1'b0,1'b0,1'b1, 1'b1,1'b0,1'b1,1'b0,1'b0},
    '{4'd5, 2'd1,3'd5,1'b0,1'b0,1'b0,1'b1,2'd0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0},
    '{4'd5, 2'd1,3'd5,1'b0,1'b0,1'b0,1'b1,2'd0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b1,1'b0,1'b0},
    '{4'd6, 2'd1,3'd6,1'b0,1'b0,1'b0,1'b1,2'd0,1'b1,1'b0,1'b0,1'b1, 1'b1,1'b0,1'b1,1'b0,1'b0},
    '{4'd6, 2'd1,3'd7,1'b0,1'b0,1'b0,1'b1,2'd0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0},
    '{4'd8, 2'd1,3'd0,1'b0,1'b0,1'b0,1'b1,2'd2,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b1,1'b0,1'b0},
    '{4'd8, 2'd1,3'd0,1'b0,1'b0,1'b0,1'b0,2'd2,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0},
    '{4'd8, 2'd1,3'd0,1'b0,1'b1,1'b0,1'b0,2'd2,1'b1,1'b0,1'b0,1'b1, 1'b1,1'b0,1'b1,1'b0,1'b0},
    '{4'd9, 2'd1,3'd0,1'b0,1'b0,1'b0,1'b0,2'd1,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0},
    '{4'd9, 2'd1,3'd0,1'b0,1'b0,1'b0,1'b0,2'd1,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b1,1'b0,1'b0},
    '{4'd9, 2'd1,3'd0,1'b0,1'b0,1'b0,1'b0,2'd0,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b1,1'b0,1'b0},
    '{4'd9, 2'd1,3'd0,1'b0,1'b0,1'b0,1'b0,2'd3,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b1,1'b0,1'b0},
    '{4'd10,2'd1,3'd4,1'b0,1'b0,1'b0,1'b1,2'd0,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b1,1'b0,1'b1},
    '{4'd10,2'd1,3'd4,1'b0,1'b0,1'b1,1'b1,2'd0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0},
    '{4'd11,2'd1,3'd0,1'b0,1'b0,1'b1,1'b1,2'd0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b1,1'b0,1'b0},
    '{4'd11,2'd1,3'd0,1'b0,1'b0,1'b1,1'b1,2'd0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0},
    '{4'd12,2'd1,3'd3,1'b1,1'b0,1'b0,1'b1,2'd0,1'b1,1'b0,1'b1,1'b0, 1'b1,1'b1,1'b1,1'b0,1'b0},
    '{4'd12,2'd1,3'd1,1'b0,1'b1,1'b0,1'b1,2'd0,1'b0,1'b0,1'b1,1'b0, 1'b1,1'b1,1'b1,1'b0,1'b0},
    '{4'd12,2'd1,3'd3,1'b1,1'b0,1'b0,1'b1,2'd0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0},
    '{4'd13,2'd1,3'd1,1'b0,1'b0,1'b0,1'b1,2'd0,1'b1,1'b1,1'b0,1'b0, 1'b1,1'b0,1'b1,1'b0,1'b0},
    '{4'd14,2'd0,3'd3,1'b0,1'b1,1'b0,1'b1,2'd0,1'b1,1'b0,1'b1,1'b0, 1'b1,1'b1,1'b0,1'b0,1'b0},
    '{4'd0, 2'd2,3'd3,1'b0,1'b0,1'b0,1'b1,2'd0,1'b1,1'b0,1'b1,1'b0, 1'b1,1'b1,1'b0,1'b0,1'b1},
    '{4'd0, 2'd3,3'd4,1'b0,1'b0,1'b0,1'b1,2'd0,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b0,1'b1,1'b0}
  };

  localparam string TAGS [NV] = '{
    "R2", "R3", "R4", "R7", "R7", "R7", "R7", "R7", "R7", "R7", "R7",
    "R7", "R7", "R6", "R6", "R6", "R6", "R6", "R6", "R6", "R8", "R5",
    "R5", "R5", "R9", "R9", "R9", "R12", "R9", "R4", "R3"
  };

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 req_vld = 1'b0;
  logic [DOM_W-1:0]     dom_idx = '0;
  logic [2:0]           ap_bits = '0;
  logic                 xn = 1'b0, page_lvl = 1'b0, afe_en = 1'b0, xp_en = 1'b0;
  logic [1:0]           rs_sel = '0;
  logic [2*NUM_DOM-1:0] dac_word = '0;
  logic                 core_priv = 1'b0, force_user = 1'b0;
  logic                 is_fetch = 1'b0, is_write = 1'b0;
  logic                 rsp_vld, allow, fault, abort_kind, cause, mgr_bypass, unpred, rep_wr;
  logic [3:0]           fault_code;
  logic [DOM_W-1:0]     rep_dom;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  acc_guard #(.NUM_DOM(NUM_DOM)) dut_i (
    .clk(clk), .rst(rst), .req_vld(req_vld), .dom_idx(dom_idx), .ap_bits(ap_bits),
    .xn(xn), .page_lvl(page_lvl), .dac_word(dac_word), .afe_en(afe_en),
    .xp_en(xp_en), .rs_sel(rs_sel), .core_priv(core_priv), .force_user(force_user),
    .is_fetch(is_fetch), .is_write(is_write), .rsp_vld(rsp_vld), .allow(allow),
    .fault(fault), .abort_kind(abort_kind), .cause(cause), .fault_code(fault_code),
    .mgr_bypass(mgr_bypass), .unpred(unpred), .rep_dom(rep_dom), .rep_wr(rep_wr)
  );

  function automatic logic [OW-1:0] outs();
    return {fault, abort_kind, cause, mgr_bypass, unpred, fault_code, rep_dom, rep_wr, allow, rsp_vld};
  endfunction

  task automatic check(string tag, logic [OW-1:0] act, logic [OW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(vec_t v);
    for (int i = 0; i < NUM_DOM; i++)
      dac_word[2*i +: 2] = (i == int'(v.dom)) ? v.mode : ~v.mode;
    req_vld    = 1'b1;
    dom_idx    = v.dom;
    ap_bits    = v.ap;
    xn         = v.xn;
    page_lvl   = v.pg;
    afe_en     = v.afe;
    xp_en      = v.xp;
    rs_sel     = v.rs;
    core_priv  = v.priv;
    force_user = v.fuser;
    is_fetch   = v.fetch;
    is_write   = v.wr;
  endtask

  // Expected outputs derived from R9, R10 and R11
  function automatic logic [OW-1:0] expect_of(vec_t v);
    logic [3:0]       code;
    logic [DOM_W-1:0] rd;
    logic             rw;
    code = v.flt ? {v.cs, 1'b1, v.pg, 1'b1} : 4'd0;
    rd   = (v.flt && !v.kind) ? v.dom : '0;
    rw   = v.flt && !v.kind && v.wr;
    return {v.flt, v.kind, v.cs, v.byp, v.unp, code, rd, rw, !v.flt, 1'b1};
  endfunction

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    // R13: reset state
    check("R13", outs(), '0);

    @(negedge clk);
    rst = 1'b0;

    // Vector table, back-to-back requests (R1 latency on each)
    for (int k = 0; k < NV; k++) begin
      drive(VECS[k]);
      @(negedge clk);
      check(TAGS[k], outs(), expect_of(VECS[k]));
    end

    // R1: idle cycle clears the outputs
    req_vld = 1'b0;
    @(negedge clk);
    check("R1", outs(), '0);

    // R10: permission fault on a page reports 4'b1111
    v = VECS[4];
    drive(v);
    @(negedge clk);
    check("R10", {28'd0, fault_code}, 32'hF);

    // R11: data write fault on domain 5 reports domain and write flag
    v = VECS[8];
    drive(v);
    @(negedge clk);
    check("R11", {27'd0, rep_dom, rep_wr}, {27'd0, 4'd5, 1'b1});

    // R13: reset wins over a request in the same cycle
    v = VECS[3];
    drive(v);
    rst = 1'b1;
    @(negedge clk);
    check("R13", outs(), '0);
    rst = 1'b0;
    req_vld = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

endmodule